// File: doc/BRIEF.md
# Synchronous SRAM Write Access Controller

This block sits in front of a synchronous SRAM whose data pins are shared between reading and writing. Each clock it looks at two address strobes, three chip enables and the write inputs. It decides whether an access starts, which address the access uses, and whether the access reads or writes. For a write it also decides which bytes are written. Its outputs are an address, a write strobe per byte, a read qualifier for the memory array, and an enable for the array's output drivers on the shared bus.

The two strobes have different latencies. An access opened by the processor strobe latches the address in its own cycle. The array access happens on the following edge, and the write inputs are sampled on that second edge. An access opened by the controller strobe reaches the array in the same cycle, using the address pins directly, and the address register is loaded at the same time. While an access is open and no strobe is low, an advance input continues the access at the held address. Any deselected strobe cycle closes the open access. The burst counter, sleep logic and error correction belong to other blocks.

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset, with no strobe low and the advance input low, no byte strobe, no read and no bus drive are active.
- R2: The device is selected only when `ce_a_n` is 0, `ce_b` is 1 and `ce_c_n` is 0. A strobe cycle with any enable inactive starts no access and loads no address.
- R3: A processor-strobe start (`proc_strb_n` low while selected) makes no array access in its own cycle. In the next cycle it accesses the address latched at the start, whatever `addr_i` shows then, and the write inputs of that second cycle decide the access.
- R4: When `gwr_n` is 0 during an access, all byte strobes are 1, whatever `bwen_n` and `bsel_n` show.
- R5: When `gwr_n` is 1 and `bwen_n` is 0, byte strobe i is 1 exactly when `bsel_n[i]` is 0, and byte i covers data bits 8i+7..8i. Bytes that are not selected keep their stored value.
- R6: An access with no write input active (`gwr_n` 1 and `bwen_n` 1) is a read. `mem_rd_o` is 1 and all byte strobes are 0.
- R7: A controller-strobe start (`ctrl_strb_n` low, `proc_strb_n` high, selected) accesses `addr_i` in the same cycle and loads it into the address register.
- R8: When both strobes are low in one selected cycle, the processor strobe wins. That cycle has no access, and the next cycle accesses the address from that cycle.
- R9: The advance input has no effect in a cycle that loads an address. A processor start with advance low makes no access, and a controller start with advance low uses `addr_i`.
- R10: Once an access has completed, a cycle with no strobe low and `adv_n` 0 repeats the access at the held address. With `adv_n` 1 it makes no access.
- R11: `bus_drive_o` is 1 only in a read access with `oe_n` 0. It is 0 in every write cycle, whatever `oe_n` shows.
- R12: A controller strobe in the completion cycle of a processor access is not accepted. The completion uses the latched address, and the address register keeps that address.
- R13: A deselected strobe cycle ends the open access, so a following advance cycle makes no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Address pins |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| gwr_n | input | 1 | Write all bytes, active low |
| bwen_n | input | 1 | Enable for byte selects, active low |
| bsel_n | input | BYTES | Per-byte select, active low |
| adv_n | input | 1 | Continue the open access, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata_i | input | BYTES*BYTE_W | Write data from the shared bus |
| mem_addr_o | output | ADDR_W | Array address |
| mem_wstrb_o | output | BYTES | Array byte write strobes |
| mem_wdata_o | output | BYTES*BYTE_W | Array write data |
| mem_rd_o | output | 1 | Array read access |
| bus_drive_o | output | 1 | Enable for the array's drivers on the shared bus |

## Verification
The bench builds the block with ADDR_W = 6, BYTES = 4 and BYTE_W = 8. This gives a 64-word memory model that the bench can clear fully and inspect word by word. With four bytes, alternating select patterns show that unselected bytes are left intact. The narrow address lets the bench pick distinct addresses for each scenario, so a write to the wrong address, such as the rejected address during a pending completion, shows up as a changed word.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PEND = 2'd1,
    ACC_CTRL = 2'd2,
    ACC_CONT = 2'd3
  } acc_kind_e;

  function automatic logic chips_on(input logic en_a_n, input logic en_b,
                                    input logic en_c_n);
    return !en_a_n && en_b && !en_c_n;
  endfunction

endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int BYTES = 4
) (
  input  logic             proc_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             ce_a_n,
  input  logic             ce_b,
  input  logic             ce_c_n,
  input  logic             gwr_n,
  input  logic             bwen_n,
  input  logic [BYTES-1:0] bsel_n,
  output logic             sel,
  output logic             strb_idle,
  output logic             p_start,
  output logic             c_req,
  output logic             desel,
  output logic [BYTES-1:0] mask
);
  import sram_wr_pkg::*;

  // Global write wins; otherwise the select pair picks bytes.
  function automatic logic [BYTES-1:0] byte_mask(input logic g_n,
                                                 input logic be_n,
                                                 input logic [BYTES-1:0] s_n);
    logic [BYTES-1:0] m;
    for (int i = 0; i < BYTES; i++) begin
      m[i] = !g_n || (!be_n && !s_n[i]);
    end
    return m;
  endfunction

  always_comb begin
    sel       = chips_on(ce_a_n, ce_b, ce_c_n);
    strb_idle = proc_strb_n && ctrl_strb_n;
    p_start   = !proc_strb_n && sel;
    c_req     = proc_strb_n && !ctrl_strb_n && sel;
    desel     = !strb_idle && !sel;
    mask      = byte_mask(gwr_n, bwen_n, bsel_n);
  end

endmodule

// File: rtl/sram_wr_areg.sv
module sram_wr_areg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              p_start,
  input  logic              c_req,
  input  logic              desel,
  output logic [ADDR_W-1:0] addr_q,
  output logic              pend_q,
  output logic              active_q,
  output logic              load_c
);

  // A controller strobe is refused while a processor access completes.
  assign load_c = c_req && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      pend_q <= p_start;
      if (p_start || load_c) begin
        addr_q <= addr_i;
      end
      if (desel) begin
        active_q <= 1'b0;
      end else if (load_c || pend_q) begin
        active_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_wr_route.sv
module sram_wr_route #(
  parameter int ADDR_W = 10,
  parameter int BYTES  = 4
) (
  input  logic              pend_q,
  input  logic              load_c,
  input  logic              active_q,
  input  logic              adv_n,
  input  logic              strb_idle,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [BYTES-1:0]  mask,
  output logic              acc_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]  wstrb,
  output logic              rd,
  output logic              drive
);
  import sram_wr_pkg::*;

  acc_kind_e kind;

  always_comb begin
    if (pend_q) begin
      kind = ACC_PEND;
    end else if (load_c) begin
      kind = ACC_CTRL;
    end else if (active_q && !adv_n && strb_idle) begin
      kind = ACC_CONT;
    end else begin
      kind = ACC_NONE;
    end
    mem_addr = (kind == ACC_CTRL) ? addr_i : addr_q;
    acc_en   = (kind != ACC_NONE);
    wstrb    = acc_en ? mask : '0;
    rd       = acc_en && (mask == '0);
    drive    = rd && !oe_n;
  end

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl #(
  parameter int ADDR_W = 10,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    proc_strb_n,
  input  logic                    ctrl_strb_n,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    gwr_n,
  input  logic                    bwen_n,
  input  logic [BYTES-1:0]        bsel_n,
  input  logic                    adv_n,
  input  logic                    oe_n,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [BYTES-1:0]        mem_wstrb_o,
  output logic [BYTES*BYTE_W-1:0] mem_wdata_o,
  output logic                    mem_rd_o,
  output logic                    bus_drive_o
);

  logic              sel;
  logic              strb_idle;
  logic              p_start;
  logic              c_req;
  logic              desel;
  logic [BYTES-1:0]  mask;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q;
  logic              active_q;
  logic              load_c;
  logic              acc_en;

  sram_wr_decode #(.BYTES(BYTES)) i_decode (
    .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .gwr_n      (gwr_n),
    .bwen_n     (bwen_n),
    .bsel_n     (bsel_n),
    .sel        (sel),
    .strb_idle  (strb_idle),
    .p_start    (p_start),
    .c_req      (c_req),
    .desel      (desel),
    .mask       (mask)
  );

  sram_wr_areg #(.ADDR_W(ADDR_W)) i_areg (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .p_start (p_start),
    .c_req   (c_req),
    .desel   (desel),
    .addr_q  (addr_q),
    .pend_q  (pend_q),
    .active_q(active_q),
    .load_c  (load_c)
  );

  sram_wr_route #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_route (
    .pend_q   (pend_q),
    .load_c   (load_c),
    .active_q (active_q),
    .adv_n    (adv_n),
    .strb_idle(strb_idle),
    .oe_n     (oe_n),
    .addr_i   (addr_i),
    .addr_q   (addr_q),
    .mask     (mask),
    .acc_en   (acc_en),
    .mem_addr (mem_addr_o),
    .wstrb    (mem_wstrb_o),
    .rd       (mem_rd_o),
    .drive    (bus_drive_o)
  );

  assign mem_wdata_o = wdata_i;

endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
  parameter int ADDR_W = 10,
  parameter int BYTES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              oe_n,
  input logic              gwr_n,
  input logic              sel,
  input logic              strb_idle,
  input logic              p_start,
  input logic              pend_q,
  input logic              load_c,
  input logic              acc_en,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BYTES-1:0]  mem_wstrb_o,
  input logic              mem_rd_o,
  input logic              bus_drive_o
);

  p_no_drive_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wstrb_o != '0) |-> !bus_drive_o);

  p_drive_needs_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_o |-> (!oe_n && mem_rd_o));

  p_read_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (mem_wstrb_o == '0));

  p_global_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !gwr_n) |-> (mem_wstrb_o == {BYTES{1'b1}}));

  p_proc_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_start && !pend_q) |-> (mem_wstrb_o == '0 && !mem_rd_o));

  p_proc_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    p_start |=> (pend_q && mem_addr_o == $past(addr_i)));

  p_ctrl_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_c |-> (mem_addr_o == addr_i));

  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_idle && !sel && !pend_q) |-> (mem_wstrb_o == '0 && !mem_rd_o));

endmodule

bind sram_wr_ctrl sram_wr_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_i     (addr_i),
  .oe_n       (oe_n),
  .gwr_n      (gwr_n),
  .sel        (sel),
  .strb_idle  (strb_idle),
  .p_start    (p_start),
  .pend_q     (pend_q),
  .load_c     (load_c),
  .acc_en     (acc_en),
  .mem_addr_o (mem_addr_o),
  .mem_wstrb_o(mem_wstrb_o),
  .mem_rd_o   (mem_rd_o),
  .bus_drive_o(bus_drive_o)
);

// File: tb/test_sram_wr_ctrl.sv
module test_sram_wr_ctrl;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          proc_strb_n = 1'b1, ctrl_strb_n = 1'b1;
  logic          ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
  logic          gwr_n = 1'b1, bwen_n = 1'b1;
  logic [NB-1:0] bsel_n = '1;
  logic          adv_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] wdata_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic [NB-1:0] mem_wstrb_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_rd_o, bus_drive_o;

  logic [DW-1:0] mem [2**AW];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_wr_ctrl #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) i_sram_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .gwr_n(gwr_n), .bwen_n(bwen_n), .bsel_n(bsel_n),
    .adv_n(adv_n), .oe_n(oe_n), .wdata_i(wdata_i),
    .mem_addr_o(mem_addr_o), .mem_wstrb_o(mem_wstrb_o),
    .mem_wdata_o(mem_wdata_o), .mem_rd_o(mem_rd_o), .bus_drive_o(bus_drive_o)
  );

  // Behavioural array written at the rising edge.
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (mem_wstrb_o[b]) mem[mem_addr_o][b*BW +: BW] <= mem_wdata_o[b*BW +: BW];
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Next cycle with the given strobes and write inputs; others idle.
  task automatic cyc(input logic p_n, input logic c_n, input logic [AW-1:0] a,
                     input logic g_n, input logic be_n, input logic [NB-1:0] s_n,
                     input logic [DW-1:0] d, input logic av_n, input logic o_n);
    @(negedge clk);
    proc_strb_n = p_n; ctrl_strb_n = c_n; addr_i = a;
    gwr_n = g_n; bwen_n = be_n; bsel_n = s_n; wdata_i = d;
    adv_n = av_n; oe_n = o_n;
    #1;
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, '0, 1'b1, 1'b1, '1, '0, 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    cyc(1'b1, 1'b1, 6'd3, 1'b0, 1'b1, '1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check("R1 strobes after reset", mem_wstrb_o, 0);
    check("R1 read after reset", mem_rd_o, 0);
    check("R1 drive after reset", bus_drive_o, 0);
  endtask

  task automatic t_proc_global();
    cyc(1'b0, 1'b1, 6'd5, 1'b0, 1'b1, '1, 32'h0, 1'b1, 1'b1);
    check("R3 no access in start cycle", {mem_wstrb_o, mem_rd_o}, 0);
    cyc(1'b1, 1'b1, 6'd9, 1'b0, 1'b1, 4'b1111, 32'hCAFE_F00D, 1'b1, 1'b0);
    check("R3 latched address", mem_addr_o, 5);
    check("R4 global write all bytes", mem_wstrb_o, 4'hF);
    check("R11 no drive on write with oe low", bus_drive_o, 0);
    idle();
    check("R3 word written", mem[5], 32'hCAFE_F00D);
    check("R3 later address untouched", mem[9], 0);
  endtask

  task automatic t_ctrl_bytes();
    cyc(1'b1, 1'b0, 6'd7, 1'b0, 1'b0, 4'b1010, 32'h1122_3344, 1'b1, 1'b1);
    check("R7 same-cycle address", mem_addr_o, 7);
    check("R4 global overrides selects", mem_wstrb_o, 4'hF);
    cyc(1'b1, 1'b0, 6'd7, 1'b1, 1'b0, 4'b1010, 32'hAABB_CCDD, 1'b1, 1'b1);
    check("R5 byte strobes", mem_wstrb_o, 4'b0101);
    idle();
    check("R5 unselected bytes kept", mem[7], 32'h11BB_33DD);
  endtask

  task automatic t_read_drive();
    cyc(1'b1, 1'b0, 6'd7, 1'b1, 1'b1, 4'b0000, 32'h0, 1'b1, 1'b0);
    check("R6 read qualifier", mem_rd_o, 1);
    check("R6 no strobes on read", mem_wstrb_o, 0);
    check("R11 drive on read with oe low", bus_drive_o, 1);
    cyc(1'b1, 1'b0, 6'd7, 1'b1, 1'b1, '1, 32'h0, 1'b1, 1'b1);
    check("R11 no drive with oe high", bus_drive_o, 0);
    idle();
    check("R6 read leaves word", mem[7], 32'h11BB_33DD);
  endtask

  task automatic t_both();
    cyc(1'b0, 1'b0, 6'd12, 1'b0, 1'b1, '1, 32'h0, 1'b1, 1'b1);
    check("R8 no access when both low", {mem_wstrb_o, mem_rd_o}, 0);
    cyc(1'b1, 1'b1, 6'd13, 1'b0, 1'b1, '1, 32'hC0FF_EE00, 1'b1, 1'b1);
    check("R8 processor address next cycle", mem_addr_o, 12);
    check("R8 write next cycle", mem_wstrb_o, 4'hF);
    idle();
    check("R8 word written", mem[12], 32'hC0FF_EE00);
  endtask

  task automatic t_adv();
    cyc(1'b1, 1'b0, 6'd7, 1'b1, 1'b1, '1, 32'h0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 6'd30, 1'b0, 1'b1, '1, 32'h5566_7788, 1'b0, 1'b1);
    check("R10 continue at held address", mem_addr_o, 7);
    check("R10 continue writes", mem_wstrb_o, 4'hF);
    cyc(1'b1, 1'b1, 6'd30, 1'b0, 1'b1, '1, 32'h9999_9999, 1'b1, 1'b1);
    check("R10 advance high no access", mem_wstrb_o, 0);
    cyc(1'b1, 1'b0, 6'd20, 1'b0, 1'b1, '1, 32'h0A0B_0C0D, 1'b0, 1'b1);
    check("R9 controller load ignores advance", mem_addr_o, 20);
    cyc(1'b0, 1'b1, 6'd21, 1'b0, 1'b1, '1, 32'h7777_7777, 1'b0, 1'b1);
    check("R9 processor load ignores advance", {mem_wstrb_o, mem_rd_o}, 0);
    cyc(1'b1, 1'b1, 6'd0, 1'b1, 1'b1, '1, 32'h0, 1'b1, 1'b1);
    check("R3 read at latched address", {mem_addr_o, mem_rd_o}, {6'd21, 1'b1});
    idle();
    check("R10 held word written", mem[7], 32'h5566_7788);
    check("R9 loaded word written", mem[20], 32'h0A0B_0C0D);
    check("R9 old address not written", mem[21], 0);
  endtask

  task automatic t_desel();
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 1'b0, 6'd7, 1'b1, 1'b1, '1, 32'h0, 1'b1, 1'b1);
      @(negedge clk);
      ce_a_n = (k == 0); ce_b = (k != 1); ce_c_n = (k == 2);
      proc_strb_n = 1'b1; ctrl_strb_n = 1'b0; addr_i = 6'd30;
      gwr_n = 1'b0; wdata_i = 32'hDEAD_0000 + k; adv_n = 1'b0;
      #1;
      check($sformatf("R2 deselect by enable %0d", k), {mem_wstrb_o, mem_rd_o}, 0);
      @(negedge clk);
      ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
      ctrl_strb_n = 1'b1; adv_n = 1'b0;
      #1;
      check($sformatf("R13 access closed after enable %0d", k), {mem_wstrb_o, mem_rd_o}, 0);
    end
    idle();
    check("R2 deselected address untouched", mem[30], 0);
    check("R13 held address untouched", mem[7], 32'h5566_7788);
  endtask

  task automatic t_pend();
    cyc(1'b0, 1'b1, 6'd40, 1'b1, 1'b1, '1, 32'h0, 1'b1, 1'b1);
    cyc(1'b1, 1'b0, 6'd41, 1'b0, 1'b1, '1, 32'h4040_4040, 1'b1, 1'b1);
    check("R12 completion keeps latched address", mem_addr_o, 40);
    cyc(1'b1, 1'b1, 6'd41, 1'b0, 1'b1, '1, 32'h1234_5678, 1'b0, 1'b1);
    check("R12 register not reloaded", mem_addr_o, 40);
    idle();
    check("R12 word at latched address", mem[40], 32'h1234_5678);
    check("R12 refused address untouched", mem[41], 0);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_proc_global();
    t_ctrl_bytes();
    t_read_drive();
    t_both();
    t_adv();
    t_desel();
    t_pend();
    summary();
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

endmodule